// File: doc/BRIEF.md
# Glitch-Free Clock Output Selector and Divider

This block drives one clock output from a choice of four free-running clocks: an internal RC oscillator, a crystal oscillator, a low-frequency oscillator and the main clock. The chosen clock then passes through an 8-bit integer divider. The divider can also stop the output altogether.

Software controls the block through a plain register port that runs on the system clock. A new source is written into a pending select field, but the output keeps its current source until software writes the update bit to 0 and then to 1. That transition commits the pending value. The switch from the old clock to the new one uses a per-source enable handshake. Each enable is synchronised into its own clock domain and changes only while that clock is low, so the output never carries a shortened pulse.

A change of divider value is picked up at the next output period boundary. A value of 0 holds the output low.

Top module: `ckx_clkout`

## Requirements
- R1: Select code 0 picks the RC clock, 1 the crystal clock, 2 the low-frequency clock and 3 the main clock. Both the pending and the committed selection reset to 0.
- R2: Writing the select register (address 0, bits [1:0]) changes the pending value, which reads back at address 0. It does not change the committed source (address 3, bits [1:0]) or the output clock.
- R3: The pending value is committed one system clock cycle after the stored update bit (address 1, bit 0) changes from 0 to 1. Writing 1 while the bit is already 1 commits nothing.
- R4: The update bit resets to 0 and reads back as written. Bits [31:1] of address 1 read as 0.
- R5: The divider register (address 2, bits [7:0]) resets to 1. A value of 1 passes the selected clock through unchanged.
- R6: A divider value of 0 holds the output clock low.
- R7: A divider value N from 2 to 255 gives an output period of N source cycles, with a high phase of ceil(N/2) cycles and a low phase of floor(N/2) cycles. A new divider value applies from the next period boundary.
- R8: At most one source clock is enabled into the output at any time.
- R9: Reserved bits read as 0: bits [31:2] at addresses 0 and 3, and bits [31:8] at address 2. Address 3 returns the committed selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the register port |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register address: 0 select, 1 update, 2 divider, 3 committed source |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, available in the same cycle |
| clk_rc | input | 1 | Internal RC oscillator clock (code 0) |
| clk_xtal | input | 1 | Crystal oscillator clock (code 1) |
| clk_lf | input | 1 | Low-frequency oscillator clock (code 2) |
| clk_main | input | 1 | Main clock (code 3) |
| clk_out | output | 1 | Selected and divided output clock |

## Verification
The bound checker checks the following on every system clock cycle:
- The commit rule: the committed source equals the pending value after a rising update bit, and holds steady otherwise.
- The one-hot-or-none state of the source enables.
- That the output stays low while the active divisor is 0.
- The zero reserved bits on every read.

Only the bench's scenarios can show the analogue timing properties. These are the measured high and low phase lengths of the output for each source and divisor, the passthrough at divisor 1, and that the output resumes after the divider is restarted from 0.

// File: rtl/ckx_pkg.sv
`timescale 1ns/1ps
package ckx_pkg;
    localparam int NSRC  = 4;
    localparam int SELW  = $clog2(NSRC);
    localparam int DIVW  = 8;
    localparam int DATAW = 32;
    localparam int ADDRW = 2;

    typedef enum logic [SELW-1:0] {
        SRC_RC   = 2'd0,
        SRC_XTAL = 2'd1,
        SRC_LF   = 2'd2,
        SRC_MAIN = 2'd3
    } src_e;

    typedef enum logic [ADDRW-1:0] {
        REG_SEL = 2'd0,
        REG_UPD = 2'd1,
        REG_DIV = 2'd2,
        REG_ACT = 2'd3
    } reg_e;

    typedef struct packed {
        src_e            pend;
        src_e            act;
        logic            upd;
        logic            upd_prev;
        logic [DIVW-1:0] div;
    } cfg_t;

    // length of the high phase for divisor n: ceil(n/2)
    function automatic logic [DIVW:0] high_len(input logic [DIVW-1:0] n);
        return ({1'b0, n} + {{DIVW{1'b0}}, 1'b1}) >> 1;
    endfunction
endpackage

// File: rtl/ckx_sync.sv
`timescale 1ns/1ps
module ckx_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= {STAGES{RST_VAL}};
        else     pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/ckx_swmux.sv
`timescale 1ns/1ps
module ckx_swmux #(
    parameter int NSRC   = 4,
    parameter int STAGES = 2,
    localparam int SELW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] clk_src,
    input  logic            rst,
    input  logic [SELW-1:0] sel,
    output logic [NSRC-1:0] en,
    output logic            clk_mux
);
    logic [NSRC-1:0] gated;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic            lrst;
        logic            want;
        logic            want_s;
        logic            en_q;
        logic [NSRC-1:0] others;

        ckx_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst (
            .clk(clk_src[i]), .rst(1'b0), .d(rst), .q(lrst)
        );

        always_comb begin
            others    = en;
            others[i] = 1'b0;
            want      = (sel == SELW'(i)) && (others == '0);
        end

        ckx_sync #(.W(1), .STAGES(STAGES), .RST_VAL(i == 0)) u_req (
            .clk(clk_src[i]), .rst(lrst), .d(want), .q(want_s)
        );

        // enable moves only while the source clock is low
        always_ff @(negedge clk_src[i]) begin
            if (lrst) en_q <= (i == 0);
            else      en_q <= want_s;
        end

        assign en[i]    = en_q;
        assign gated[i] = clk_src[i] & en_q;
    end

    assign clk_mux = |gated;
endmodule

// File: rtl/ckx_div.sv
`timescale 1ns/1ps
module ckx_div
    import ckx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic            mclk,
    input  logic            rst,
    input  logic [DIVW-1:0] div_val,
    output logic [DIVW-1:0] cur_n,
    output logic            clk_out
);
    logic            lrst;
    logic [DIVW-1:0] n_sync;
    logic [DIVW-1:0] cnt;
    logic            q;
    logic [DIVW:0]   cnt_nx;

    ckx_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst (
        .clk(mclk), .rst(1'b0), .d(rst), .q(lrst)
    );

    ckx_sync #(.W(DIVW), .STAGES(STAGES), .RST_VAL(DIVW'(1))) u_val (
        .clk(mclk), .rst(lrst), .d(div_val), .q(n_sync)
    );

    assign cnt_nx = {1'b0, cnt} + {{DIVW{1'b0}}, 1'b1};

    always_ff @(posedge mclk) begin
        if (lrst) begin
            cnt   <= '0;
            cur_n <= DIVW'(1);
            q     <= 1'b1;
        end else if (cnt_nx >= {1'b0, cur_n}) begin
            // period boundary: adopt the new divisor
            cnt   <= '0;
            cur_n <= n_sync;
            q     <= (n_sync != '0);
        end else begin
            cnt   <= cnt_nx[DIVW-1:0];
            q     <= (cnt_nx < high_len(cur_n));
        end
    end

    assign clk_out = (cur_n == DIVW'(1)) ? mclk : q;
endmodule

// File: rtl/ckx_clkout.sv
`timescale 1ns/1ps
module ckx_clkout
    import ckx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [ADDRW-1:0] addr,
    input  logic [DATAW-1:0] wr_data,
    output logic [DATAW-1:0] rd_data,
    input  logic             clk_rc,
    input  logic             clk_xtal,
    input  logic             clk_lf,
    input  logic             clk_main,
    output logic             clk_out
);
    cfg_t            cfg_q;
    logic [NSRC-1:0] src_en;
    logic            clk_mux;
    logic [DIVW-1:0] cur_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.pend     <= SRC_RC;
            cfg_q.act      <= SRC_RC;
            cfg_q.upd      <= 1'b0;
            cfg_q.upd_prev <= 1'b0;
            cfg_q.div      <= DIVW'(1);
        end else begin
            cfg_q.upd_prev <= cfg_q.upd;
            if (cfg_q.upd && !cfg_q.upd_prev)
                cfg_q.act <= cfg_q.pend;
            if (wr_en) begin
                case (reg_e'(addr))
                    REG_SEL: cfg_q.pend <= src_e'(wr_data[SELW-1:0]);
                    REG_UPD: cfg_q.upd  <= wr_data[0];
                    REG_DIV: cfg_q.div  <= wr_data[DIVW-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_e'(addr))
            REG_SEL: rd_data[SELW-1:0] = cfg_q.pend;
            REG_UPD: rd_data[0]        = cfg_q.upd;
            REG_DIV: rd_data[DIVW-1:0] = cfg_q.div;
            REG_ACT: rd_data[SELW-1:0] = cfg_q.act;
            default: ;
        endcase
    end

    ckx_swmux #(.NSRC(NSRC), .STAGES(SYNC_STAGES)) u_mux (
        .clk_src({clk_main, clk_lf, clk_xtal, clk_rc}),
        .rst    (rst),
        .sel    (cfg_q.act),
        .en     (src_en),
        .clk_mux(clk_mux)
    );

    ckx_div #(.STAGES(SYNC_STAGES)) u_div (
        .mclk   (clk_mux),
        .rst    (rst),
        .div_val(cfg_q.div),
        .cur_n  (cur_n),
        .clk_out(clk_out)
    );
endmodule

// File: rtl/ckx_clkout_chk.sv
`timescale 1ns/1ps
module ckx_clkout_chk
    import ckx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [ADDRW-1:0] addr,
    input logic [DATAW-1:0] rd_data,
    input logic             upd,
    input logic [SELW-1:0]  pend,
    input logic [SELW-1:0]  act,
    input logic [NSRC-1:0]  src_en,
    input logic [DIVW-1:0]  cur_n,
    input logic             clk_out
);
    assert_commit_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(upd) |=> (act == $past(pend)));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !$rose(upd) |=> $stable(act));

    assert_one_src_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_en));

    assert_stopped_R6: assert property (@(posedge clk) disable iff (rst)
        (cur_n == '0) |-> !clk_out);

    assert_upd_rsvd_R4: assert property (@(posedge clk) disable iff (rst)
        (addr == REG_UPD) |-> (rd_data[DATAW-1:1] == '0));

    assert_sel_rsvd_R9: assert property (@(posedge clk) disable iff (rst)
        (addr == REG_SEL || addr == REG_ACT) |-> (rd_data[DATAW-1:SELW] == '0));

    assert_div_rsvd_R9: assert property (@(posedge clk) disable iff (rst)
        (addr == REG_DIV) |-> (rd_data[DATAW-1:DIVW] == '0));
endmodule

bind ckx_clkout ckx_clkout_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .addr   (addr),
    .rd_data(rd_data),
    .upd    (cfg_q.upd),
    .pend   (cfg_q.pend),
    .act    (cfg_q.act),
    .src_en (src_en),
    .cur_n  (cur_n),
    .clk_out(clk_out)
);

// File: tb/sim_ckx_clkout.sv
`timescale 1ns/1ps
module sim_ckx_clkout;
    logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        clk_rc = 1'b0, clk_xtal = 1'b0, clk_lf = 1'b0, clk_main = 1'b0;
    logic        clk_out;

    int n_vec = 0;
    int n_bad = 0;

    always #4  clk      = ~clk;
    always #5  clk_rc   = ~clk_rc;
    always #7  clk_xtal = ~clk_xtal;
    always #20 clk_lf   = ~clk_lf;
    always #3  clk_main = ~clk_main;

    ckx_clkout u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .clk_rc(clk_rc), .clk_xtal(clk_xtal),
        .clk_lf(clk_lf), .clk_main(clk_main), .clk_out(clk_out)
    );

    // {select, divisor}
    localparam logic [9:0] VEC [0:7] = '{
        {2'd0, 8'd1}, {2'd1, 8'd2}, {2'd2, 8'd3}, {2'd3, 8'd4},
        {2'd0, 8'd5}, {2'd3, 8'd1}, {2'd1, 8'd7}, {2'd2, 8'd2}
    };

    function automatic longint period_ps(input int sel);
        case (sel)
            0: return 10000;
            1: return 14000;
            2: return 40000;
            default: return 6000;
        endcase
    endfunction

    task automatic check(input string tag, input longint got, input longint exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rd_data;
    endtask

    task automatic settle();
        repeat (150) @(negedge clk);
    endtask

    task automatic measure(output longint hi, output longint lo);
        realtime t0, t1, t2;
        @(posedge clk_out); t0 = $realtime;
        @(negedge clk_out); t1 = $realtime;
        @(posedge clk_out); t2 = $realtime;
        hi = longint'((t1 - t0) * 1000.0);
        lo = longint'((t2 - t1) * 1000.0);
    endtask

    task automatic commit();
        wr(2'd1, 32'd0);
        wr(2'd1, 32'd1);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        longint hi, lo;
        repeat (20) @(negedge clk);
        rst = 1'b0;
        settle();

        // reset state
        rd(2'd0, v); check("R1 reset pending select", v, 0);
        rd(2'd3, v); check("R1 reset committed select", v, 0);
        rd(2'd1, v); check("R4 reset update bit", v, 0);
        rd(2'd2, v); check("R5 reset divider", v, 1);
        measure(hi, lo);
        check("R5 reset passthrough high", hi, 5000);
        check("R5 reset passthrough low", lo, 5000);

        // R2: staging a select alone changes nothing visible at the output
        wr(2'd0, 32'd3);
        rd(2'd0, v); check("R2 pending readback", v, 3);
        settle();
        rd(2'd3, v); check("R2 committed unchanged", v, 0);
        measure(hi, lo); check("R2 output source unchanged", hi, 5000);

        // vector table: source and divisor combinations
        for (int k = 0; k < 8; k++) begin
            int sel, n;
            longint per, ehi, elo;
            sel = int'(VEC[k][9:8]);
            n   = int'(VEC[k][7:0]);
            per = period_ps(sel);
            ehi = (n == 1) ? per / 2 : per * ((n + 1) / 2);
            elo = (n == 1) ? per / 2 : per * (n / 2);
            wr(2'd0, 32'(sel));
            wr(2'd2, 32'(n));
            commit();
            settle();
            rd(2'd3, v); check("R1 R3 committed source", v, sel);
            measure(hi, lo);
            if (n == 1) begin
                check("R5 R1 passthrough high", hi, ehi);
                check("R5 R1 passthrough low", lo, elo);
            end else begin
                check("R7 R1 divided high", hi, ehi);
                check("R7 R1 divided low", lo, elo);
            end
        end

        // R3: a write of 1 while the bit is already 1 commits nothing
        wr(2'd0, 32'd1);
        wr(2'd1, 32'd1);
        settle();
        rd(2'd3, v); check("R3 repeated one ignored", v, 2);
        measure(hi, lo); check("R3 output still low-freq source", hi, 40000);
        commit();
        settle();
        rd(2'd3, v); check("R3 zero-then-one commits", v, 1);
        measure(hi, lo); check("R3 output on crystal source", hi, 14000);

        // R4: update bit readback and its reserved bits
        wr(2'd1, 32'hFFFF_FFFE);
        rd(2'd1, v); check("R4 update bit cleared", v, 0);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); check("R4 update bit set, reserved zero", v, 1);

        // R9: reserved bits of select, divider and committed source
        wr(2'd0, 32'hFFFF_FFFD);
        rd(2'd0, v); check("R9 select reserved bits", v, 1);
        wr(2'd2, 32'hABCD_1203);
        rd(2'd2, v); check("R9 divider reserved bits", v, 3);
        rd(2'd3, v); check("R9 committed source readback", v, 1);

        // R6: divisor 0 stops the output
        wr(2'd2, 32'd0);
        settle();
        begin
            int highs = 0;
            for (int s = 0; s < 60; s++) begin
                #7;
                if (clk_out) highs++;
            end
            check("R6 output held low", highs, 0);
        end

        // R7: restart from 0 with divisor 4 on the crystal clock
        wr(2'd2, 32'd4);
        settle();
        measure(hi, lo);
        check("R7 restart high", hi, 28000);
        check("R7 restart low", lo, 28000);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule